// File: doc/BRIEF.md
# Programmable Interval Interrupt Timer

This block produces processor interrupts at one of seven fixed intervals. It counts the 10 Hz setting pulse of a clock divider chain. A four-bit configuration word selects the interval and chooses between one-shot and periodic operation. A separate halt bit starts the timer and stops it. When a stop is requested, the partial count is discarded, so the next start always yields a whole interval.

Each timeout does three things. It emits a one-cycle timeout pulse for the neighbouring status logic. It sets a pending flag, and that flag drives an active-low interrupt line. The status logic clears the flag with a clear strobe. In periodic mode the counter wraps at the moment of each timeout, so every later timeout keeps the phase of the first and the intervals never drift.

Top module: `ivt_timer`

## Requirements
- R1: After reset the interrupt line is high, the pending flag is 0, the timeout pulse is 0, the halt bit reads 1, the timer is not running, and the stored selector is 000.
- R2: Bits [2:0] of the configuration word choose the interval in 10 Hz ticks: 001→1, 010→5, 011→10, 100→50, 101→100, 110→300, 111→600. A run that starts at tick count zero times out on exactly that many counted ticks.
- R3: Bit 3 of the configuration word chooses the mode: 0 gives one-shot and 1 gives periodic.
- R4: Writing the halt bit to 0 while a non-zero selector is held starts the timer from a zero count. The timeout pulse is high for one cycle, in the cycle after the clock edge that samples the final tick.
- R5: Writing the halt bit to 1 stops the timer and discards its count. A later restart needs a full interval of ticks before the next timeout.
- R6: Writing selector 000 clears the pending flag, sets the halt bit to 1 and stops the timer. While the selector is 000, writing the halt bit to 0 leaves the halt bit at 1 and the timer idle.
- R7: In one-shot mode the timer stops after its timeout and gives no further timeouts until the halt bit is written to 0 again. The halt bit keeps reading 0 during this time.
- R8: In periodic mode, timeouts repeat every interval without any further write. The k-th timeout falls on the counted tick number k×interval after the start.
- R9: A timeout sets the pending flag, and the interrupt line is low exactly while the flag is set. The clear strobe resets the flag. A timeout in the same cycle as the clear strobe wins, so the flag stays set.
- R10: Ticks have no effect while the timer is halted or finished. A write of a non-zero selector neither starts nor stops the timer.
- R11: Priority within one cycle: a write of selector 000 overrides a halt-bit write, and a halt-bit write overrides tick counting, which gives no timeout that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_10hz | input | 1 | One-cycle strobe per 10 Hz setting pulse |
| icfg_we | input | 1 | Write strobe for the configuration word |
| icfg_wdata | input | 4 | Configuration word: [3] mode, [2:0] interval selector |
| ctl_we | input | 1 | Write strobe for the halt bit |
| ctl_halt | input | 1 | Halt value written: 1 stops, 0 starts |
| pend_clr | input | 1 | Clear strobe for the pending flag |
| irq_n | output | 1 | Interrupt line, active low |
| irq_pend | output | 1 | Pending flag |
| timeout_pulse | output | 1 | One-cycle pulse per timeout |
| halt_bit | output | 1 | Current halt bit |
| running | output | 1 | High while the timer is counting |

## Verification
Four properties hold on every cycle and are checked by the assertions. A timeout pulse always follows a sampled tick. It always coincides with a low interrupt line. It never comes from an idle timer. A zero-selector write always leaves the halt bit set and the flag clear.

Other behaviour only shows over whole runs, and the bench's scenarios cover it. These are the exact tick count for each selector, the fixed phase of periodic timeouts, the one-shot stop, a full interval after a restart, and the tie between a timeout and a clear. A behavioural model in the bench compares every output on each cycle through these scenarios.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

    typedef enum logic [1:0] {
        TS_HALT = 2'd0,
        TS_RUN  = 2'd1,
        TS_DONE = 2'd2
    } tstate_e;

    typedef struct packed {
        logic       rep;
        logic [2:0] sel;
    } icfg_t;

    localparam int unsigned LONGEST_TICKS = 600;

    // interval length in 10 Hz ticks; 0 means no interval programmed
    function automatic logic [15:0] sel_ticks(input logic [2:0] sel);
        logic [15:0] t;
        case (sel)
            3'd1:    t = 16'd1;
            3'd2:    t = 16'd5;
            3'd3:    t = 16'd10;
            3'd4:    t = 16'd50;
            3'd5:    t = 16'd100;
            3'd6:    t = 16'd300;
            3'd7:    t = 16'd600;
            default: t = 16'd0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/ivt_cfg.sv
module ivt_cfg
    import ivt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [3:0] cfg_wdata,
    output icfg_t      cfg_q,
    output icfg_t      cfg_eff,
    output logic       zero_wr
);
    icfg_t wr_word;

    always_comb begin
        wr_word = icfg_t'(cfg_wdata);
        cfg_eff = cfg_we ? wr_word : cfg_q;
        zero_wr = cfg_we && (wr_word.sel == 3'd0);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (cfg_we)
            cfg_q <= wr_word;
    end

    p_cfg_written_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_q == $past(wr_word)));

endmodule

// File: rtl/ivt_count.sv
module ivt_count
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       advance,
    input  logic       clear,
    input  logic [2:0] sel,
    output logic       hit,
    output logic       timeout_q
);
    localparam int unsigned EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] lim;
    logic [EXT_W-1:0] cnt_inc;

    always_comb begin
        lim     = EXT_W'(sel_ticks(sel));
        cnt_inc = {1'b0, cnt_q} + EXT_W'(1);
        // >= lets a shortened interval still expire on the next tick
        hit     = advance && tick && (lim != '0) && (cnt_inc >= lim);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            timeout_q <= 1'b0;
        end else begin
            timeout_q <= hit;
            if (clear || hit)
                cnt_q <= '0;
            else if (advance && tick)
                cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    p_timeout_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
        timeout_q |-> $past(tick));

    p_clear_restarts_r5: assert property (@(posedge clk) disable iff (rst)
        clear |=> !timeout_q);

endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
    import ivt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       run_we,
    input  logic       run_halt,
    input  logic       zero_wr,
    input  logic [2:0] eff_sel,
    input  logic       rep,
    input  logic       hit,
    input  logic       flag_clr,
    output logic       advance,
    output logic       clear,
    output logic       halt_q,
    output logic       active,
    output logic       flag_q
);
    tstate_e st_q;
    tstate_e st_d;
    logic    halt_d;
    logic    start_ok;

    always_comb begin
        start_ok = !run_halt && (eff_sel != 3'd0);
        advance  = (st_q == TS_RUN) && !run_we && !zero_wr;
        clear    = run_we || zero_wr;
        active   = (st_q == TS_RUN);
        st_d     = st_q;
        halt_d   = halt_q;
        if (zero_wr) begin
            st_d   = TS_HALT;
            halt_d = 1'b1;
        end else if (run_we) begin
            st_d   = start_ok ? TS_RUN : TS_HALT;
            halt_d = !start_ok;
        end else if (hit) begin
            st_d = rep ? TS_RUN : TS_DONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= TS_HALT;
            halt_q <= 1'b1;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            halt_q <= halt_d;
            if (zero_wr)
                flag_q <= 1'b0;
            else if (hit)
                flag_q <= 1'b1;
            else if (flag_clr)
                flag_q <= 1'b0;
        end
    end

    p_zero_sel_halts_r6: assert property (@(posedge clk) disable iff (rst)
        zero_wr |=> (halt_q && !flag_q && !active));

    p_idle_no_hit_r10: assert property (@(posedge clk) disable iff (rst)
        (st_q != TS_RUN) |-> !hit);

    p_oneshot_stops_r7: assert property (@(posedge clk) disable iff (rst)
        (hit && !rep && !run_we && !zero_wr) |=> !active);

endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
    import ivt_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_10hz,
    input  logic       icfg_we,
    input  logic [3:0] icfg_wdata,
    input  logic       ctl_we,
    input  logic       ctl_halt,
    input  logic       pend_clr,
    output logic       irq_n,
    output logic       irq_pend,
    output logic       timeout_pulse,
    output logic       halt_bit,
    output logic       running
);
    icfg_t cfg_q;
    icfg_t cfg_eff;
    logic  zero_wr;
    logic  hit;
    logic  advance;
    logic  clear;

    ivt_cfg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (icfg_we),
        .cfg_wdata (icfg_wdata),
        .cfg_q     (cfg_q),
        .cfg_eff   (cfg_eff),
        .zero_wr   (zero_wr)
    );

    ivt_count #(.CNT_W(CNT_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick_10hz),
        .advance   (advance),
        .clear     (clear),
        .sel       (cfg_q.sel),
        .hit       (hit),
        .timeout_q (timeout_pulse)
    );

    ivt_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .run_we   (ctl_we),
        .run_halt (ctl_halt),
        .zero_wr  (zero_wr),
        .eff_sel  (cfg_eff.sel),
        .rep      (cfg_q.rep),
        .hit      (hit),
        .flag_clr (pend_clr),
        .advance  (advance),
        .clear    (clear),
        .halt_q   (halt_bit),
        .active   (running),
        .flag_q   (irq_pend)
    );

    assign irq_n = !irq_pend;

    p_timeout_drives_irq_r9: assert property (@(posedge clk) disable iff (rst)
        timeout_pulse |-> !irq_n);

    p_halted_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (halt_bit && !running) |=> !timeout_pulse);

endmodule

// File: tb/tb_ivt_timer.sv
module tb_ivt_timer;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_10hz = 1'b0;
    logic       icfg_we = 1'b0;
    logic [3:0] icfg_wdata = 4'd0;
    logic       ctl_we = 1'b0;
    logic       ctl_halt = 1'b0;
    logic       pend_clr = 1'b0;
    logic       irq_n, irq_pend, timeout_pulse, halt_bit, running;

    int  total = 0;
    int  bad = 0;
    bit  tick_on = 1'b0;
    bit  done = 1'b0;

    // behavioural reference state
    int m_sel = 0, m_rep = 0, m_halt = 1, m_st = 0, m_cnt = 0, m_pend = 0, m_to = 0;
    int tick_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ivt_timer dut (
        .clk(clk), .rst(rst), .tick_10hz(tick_10hz),
        .icfg_we(icfg_we), .icfg_wdata(icfg_wdata),
        .ctl_we(ctl_we), .ctl_halt(ctl_halt), .pend_clr(pend_clr),
        .irq_n(irq_n), .irq_pend(irq_pend), .timeout_pulse(timeout_pulse),
        .halt_bit(halt_bit), .running(running)
    );

    function automatic int ticks_of(input int s);
        case (s)
            1: return 1;   2: return 5;   3: return 10;  4: return 50;
            5: return 100; 6: return 300; 7: return 600;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // ticks on every other cycle while enabled
    always @(negedge clk) tick_10hz <= tick_on ? ~tick_10hz : 1'b0;

    // reference model
    always @(posedge clk) begin
        int  esel;
        int  lim;
        bit  zw;
        if (rst) begin
            m_sel = 0; m_rep = 0; m_halt = 1; m_st = 0; m_cnt = 0; m_pend = 0; m_to = 0;
            tick_cnt = 0;
        end else begin
            zw   = icfg_we && (icfg_wdata[2:0] == 3'd0);
            esel = icfg_we ? int'(icfg_wdata[2:0]) : m_sel;
            lim  = ticks_of(m_sel);
            m_to = 0;
            if (zw) begin
                m_halt = 1; m_st = 0; m_cnt = 0; m_pend = 0;
            end else if (ctl_we) begin
                m_cnt = 0; tick_cnt = 0;
                if (ctl_halt || esel == 0) begin m_halt = 1; m_st = 0; end
                else begin m_halt = 0; m_st = 1; end
            end else if (m_st == 1 && tick_10hz) begin
                tick_cnt++;
                if (m_cnt + 1 >= lim) begin
                    m_to = 1; m_cnt = 0; m_st = m_rep ? 1 : 2;
                end else m_cnt++;
            end
            if (!zw) begin
                if (m_to) m_pend = 1;
                else if (pend_clr) m_pend = 0;
            end
            if (icfg_we) begin
                m_sel = int'(icfg_wdata[2:0]);
                m_rep = int'(icfg_wdata[3]);
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R4 timeout", int'(timeout_pulse), m_to);
            chk("R9 pending", int'(irq_pend), m_pend);
            chk("R9 irq_n", int'(irq_n), 1 - m_pend);
            chk("R6 halt", int'(halt_bit), m_halt);
            chk("R7 running", int'(running), (m_st == 1) ? 1 : 0);
        end
    end

    task automatic wr_cfg(input logic [3:0] v);
        @(negedge clk); icfg_we = 1'b1; icfg_wdata = v;
        @(negedge clk); icfg_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic h);
        @(negedge clk); ctl_we = 1'b1; ctl_halt = h;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic wait_to(input string req, input int exp_ticks);
        int n;
        n = 0;
        @(negedge clk);
        while (!timeout_pulse && n < 3000) begin @(negedge clk); n++; end
        chk(req, tick_cnt, exp_ticks);
    endtask

    task automatic count_to(input int cycles, output int seen);
        seen = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (timeout_pulse) seen++;
        end
    endtask

    initial begin
        int seen;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq_n", int'(irq_n), 1);
        chk("R1 pend", int'(irq_pend), 0);
        chk("R1 halt", int'(halt_bit), 1);
        chk("R1 running", int'(running), 0);
        chk("R1 timeout", int'(timeout_pulse), 0);
        tick_on = 1'b1;

        // R2 interval table, one-shot (R3 bit3=0)
        for (int s = 1; s <= 7; s++) begin
            wr_cfg(4'(s));
            wr_ctl(1'b0);
            wait_to("R2 ticks", ticks_of(s));
            @(negedge clk);
            chk("R7 stopped after one-shot", int'(running), 0);
            chk("R9 irq low", int'(irq_n), 0);
            pend_clr = 1'b1; @(negedge clk); pend_clr = 1'b0; @(negedge clk);
            chk("R9 cleared", int'(irq_pend), 0);
        end

        // R7: no further timeouts while finished, halt still reads 0
        count_to(40, seen);
        chk("R7 no retrigger", seen, 0);
        chk("R7 halt reads 0", int'(halt_bit), 0);

        // R3/R8 periodic mode, phase locked to start
        wr_cfg(4'b1010);
        wr_ctl(1'b0);
        wait_to("R8 first", 5);
        wait_to("R8 second", 10);
        wait_to("R8 third", 15);
        chk("R3 periodic keeps running", int'(running), 1);

        // R5 halt discards count, restart gives full interval
        wr_cfg(4'b0011);
        wr_ctl(1'b1);
        wr_ctl(1'b0);
        repeat (12) @(negedge clk);
        wr_ctl(1'b1);
        chk("R5 halted", int'(running), 0);
        count_to(60, seen);
        chk("R10 ticks ignored while halted", seen, 0);
        wr_cfg(4'b0100);
        chk("R10 cfg write keeps halt", int'(running), 0);
        wr_cfg(4'b0011);
        wr_ctl(1'b0);
        wait_to("R5 full interval", 10);

        // R9 timeout wins over simultaneous clear
        wr_cfg(4'b1001);
        pend_clr = 1'b1;
        wr_ctl(1'b0);
        @(negedge clk);
        while (!timeout_pulse) @(negedge clk);
        chk("R9 set beats clear", int'(irq_pend), 1);
        pend_clr = 1'b0;

        // R6 zero selector clears flag, forces halt, blocks start
        @(negedge clk);
        wr_cfg(4'b0000);
        chk("R6 pend cleared", int'(irq_pend), 0);
        chk("R6 halt forced", int'(halt_bit), 1);
        wr_ctl(1'b0);
        chk("R6 start refused", int'(halt_bit), 1);
        chk("R6 idle", int'(running), 0);

        // R11 zero write beats simultaneous start
        wr_cfg(4'b0010);
        @(negedge clk);
        icfg_we = 1'b1; icfg_wdata = 4'b0000; ctl_we = 1'b1; ctl_halt = 1'b0;
        @(negedge clk);
        icfg_we = 1'b0; ctl_we = 1'b0;
        chk("R11 zero wins", int'(halt_bit), 1);
        chk("R11 not running", int'(running), 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule